// File: doc/BRIEF.md
# I2C Slave Receive Engine

This block is the receive half of an I2C slave. It watches SCL and SDA, which are already synchronised to the system clock, and finds start and stop conditions. It keeps a bus-busy flag. It compares the first byte after each start with a programmable 7-bit own address and then shifts in the data bytes that follow. During each ninth clock it pulls SDA low or leaves it released, according to a software-controlled acknowledge bit.

Each finished byte moves into a receive data register that a full flag guards. One further byte can wait behind it in a holding slot. A small register port gives software the control bits, the own address, the status flags and the data register, and an interrupt line reports pending events. Reading the data register frees it, and a waiting byte moves in at once.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, the control register (address 0) reads 0, the own-address register (address 1) reads the OWN_ADDR_RST parameter, the status register (address 2) reads 0, and sda_oe and irq are 0.
- R2: SDA falling while SCL is high sets busy (status bit 3). SDA rising while SCL is high clears busy and sets the stop flag (status bit 2).
- R3: The first frame after a start carries seven address bits, MSB first, then a direction bit. The block is selected only if the address equals the own address and the direction bit is 0. Otherwise it drives nothing and ignores the bus until the next start, including a repeated start.
- R4: On the ninth clock of a selected frame, sda_oe is 1 (SDA pulled low) exactly when the acknowledge bit (control bit 0) is 0. sda_oe returns to 0 after that clock falls, and it changes only while SCL is low.
- R5: On the rising edge of the ninth clock of a selected frame, the pending flag (status bit 0) is set. The received byte, the address byte included, moves into the data register (address 3), and full (status bit 1) is set if the register was empty.
- R6: A read of the data register returns its byte and clears full. If a byte is waiting, that byte moves in, and full and pending are set again.
- R7: If the data register and the waiting slot are both occupied when a byte completes, the new byte is dropped and overrun (status bit 4) is set.
- R8: A stop condition sets pending when the stop mask (control bit 2) is 0, and leaves pending unchanged when the mask is 1.
- R9: irq equals pending AND the interrupt enable (control bit 1), delayed by one register stage.
- R10: A write to the status register clears pending, stop and overrun where the written bit (0, 2, 4) is 0 and leaves them unchanged where it is 1. The write takes effect in one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | input | 2 | Register select: 0 control, 1 own address, 2 status, 3 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 7-bit address and own address 0x3A. It sweeps all 128 addresses and checks that exactly one of them is acknowledged and that every other one leaves the block silent for the rest of the transfer. It sends all 256 byte values through the data register. Short directed sequences fill the data register and the waiting slot and then overflow them, so that the hand-over on read, the overrun flag, the stop mask, the interrupt gating and the clear-by-zero writes are all reached.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = ADDR_W + 1;
  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] RA_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] RA_OWN  = 2'd1;
  localparam logic [REG_AW-1:0] RA_STAT = 2'd2;
  localparam logic [REG_AW-1:0] RA_DATA = 2'd3;

  localparam int SB_PEND = 0;
  localparam int SB_FULL = 1;
  localparam int SB_STOP = 2;
  localparam int SB_BUSY = 3;
  localparam int SB_OVR  = 4;

  typedef struct packed {
    logic [4:0] spare;
    logic       stop_mask;
    logic       irq_en;
    logic       ack_val;
  } ctrl_t;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic busy
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_det)     busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

  a_r2_busy_on_start: assert property (@(posedge clk) disable iff (rst)
    start_det |=> busy);
  a_r2_idle_on_stop: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !busy);
endmodule

// File: rtl/i2c_rx_shifter.sv
module i2c_rx_shifter
  import i2c_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_val,
  output logic              sda_oe,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic listen, drop, in_ack, first;
  logic addr_hit;

  assign addr_hit = (shreg[DATA_W-1:1] == own_addr) && !shreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0; cnt <= '0; listen <= 1'b0; drop <= 1'b0;
      in_ack <= 1'b0; first <= 1'b0; sda_oe <= 1'b0;
      byte_done <= 1'b0; byte_val <= '0;
    end else begin
      byte_done <= 1'b0;
      if (start_det) begin
        listen <= 1'b1; drop <= 1'b0; in_ack <= 1'b0;
        cnt <= '0; first <= 1'b1; sda_oe <= 1'b0;
      end else if (stop_det) begin
        listen <= 1'b0; in_ack <= 1'b0; cnt <= '0; sda_oe <= 1'b0;
      end else if (listen && !drop) begin
        if (scl_rise) begin
          if (in_ack) begin
            byte_done <= 1'b1;
            byte_val  <= shreg;
          end else if (cnt < LAST) begin
            shreg <= {shreg[DATA_W-2:0], sda_i};
            cnt   <= cnt + 1'b1;
          end
        end
        if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0; sda_oe <= 1'b0; cnt <= '0; first <= 1'b0;
          end else if (cnt == LAST) begin
            if (first && !addr_hit) drop <= 1'b1;
            else begin
              in_ack <= 1'b1;
              sda_oe <= ~ack_val;
            end
          end
        end
      end
    end
  end

  // R4: the drive level follows the acknowledge bit, and changes only with SCL low
  a_r4_drive_follows_ack: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(!ack_val));
  a_r4_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(!scl_i || start_det || stop_det));
  a_r3_silent_when_dropped: assert property (@(posedge clk) disable iff (rst)
    drop |-> !sda_oe && !byte_done);
endmodule

// File: rtl/i2c_rx_regs.sv
module i2c_rx_regs
  import i2c_rx_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OWN_ADDR_RST = 7'h3A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_val,
  input  logic              stop_det,
  input  logic              busy,
  output logic [ADDR_W-1:0] own_addr,
  output logic              ack_val
);
  ctrl_t             ctrl_q, ctrl_n;
  logic [DATA_W-1:0] own_q, data_q, data_n, stash_q, stash_n;
  logic pend_q, pend_n, full_q, full_n, wait_q, wait_n;
  logic stop_q, stop_n, ovr_q, ovr_n;
  logic wr_stat, rd_data;
  logic [DATA_W-1:0] status;

  assign wr_stat = reg_wr && (reg_addr == RA_STAT);
  assign rd_data = reg_rd && (reg_addr == RA_DATA);

  always_comb begin
    ctrl_n = ctrl_q;
    pend_n = pend_q; full_n = full_q; wait_n = wait_q;
    stop_n = stop_q; ovr_n = ovr_q;
    data_n = data_q; stash_n = stash_q;
    if (reg_wr && reg_addr == RA_CTRL) ctrl_n = ctrl_t'(reg_wdata);
    if (wr_stat) begin
      if (!reg_wdata[SB_PEND]) pend_n = 1'b0;
      if (!reg_wdata[SB_STOP]) stop_n = 1'b0;
      if (!reg_wdata[SB_OVR])  ovr_n  = 1'b0;
    end
    if (rd_data) begin
      if (wait_q) begin
        data_n = stash_q; wait_n = 1'b0; pend_n = 1'b1;
      end else begin
        full_n = 1'b0;
      end
    end
    if (byte_done) begin
      pend_n = 1'b1;
      if (!full_n) begin
        data_n = byte_val; full_n = 1'b1;
      end else if (!wait_n) begin
        stash_n = byte_val; wait_n = 1'b1;
      end else begin
        ovr_n = 1'b1;
      end
    end
    if (stop_det) begin
      stop_n = 1'b1;
      if (!ctrl_q.stop_mask) pend_n = 1'b1;
    end
  end

  always_comb begin
    status = '0;
    status[SB_PEND] = pend_q;
    status[SB_FULL] = full_q;
    status[SB_STOP] = stop_q;
    status[SB_BUSY] = busy;
    status[SB_OVR]  = ovr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0; own_q <= {1'b0, OWN_ADDR_RST};
      pend_q <= 1'b0; full_q <= 1'b0; wait_q <= 1'b0;
      stop_q <= 1'b0; ovr_q <= 1'b0;
      data_q <= '0; stash_q <= '0; reg_rdata <= '0; irq <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      if (reg_wr && reg_addr == RA_OWN) own_q <= reg_wdata;
      pend_q <= pend_n; full_q <= full_n; wait_q <= wait_n;
      stop_q <= stop_n; ovr_q <= ovr_n;
      data_q <= data_n; stash_q <= stash_n;
      irq <= pend_n && ctrl_n.irq_en;
      if (reg_rd) begin
        case (reg_addr)
          RA_CTRL: reg_rdata <= ctrl_q;
          RA_OWN:  reg_rdata <= own_q;
          RA_STAT: reg_rdata <= status;
          default: reg_rdata <= data_q;
        endcase
      end
    end
  end

  assign own_addr = own_q[ADDR_W-1:0];
  assign ack_val  = ctrl_q.ack_val;

  a_r5_pend_on_byte: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> pend_q);
  a_r7_overrun: assert property (@(posedge clk) disable iff (rst)
    byte_done && full_q && wait_q && !rd_data |=> ovr_q);
  a_r6_read_frees: assert property (@(posedge clk) disable iff (rst)
    rd_data && !wait_q && !byte_done |=> !full_q);
  a_r6_waiting_moves_in: assert property (@(posedge clk) disable iff (rst)
    rd_data && wait_q |=> full_q && pend_q);
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_rx_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OWN_ADDR_RST = 7'h3A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic scl_rise, scl_fall, start_det, stop_det, busy;
  logic byte_done, ack_val;
  logic [DATA_W-1:0] byte_val;
  logic [ADDR_W-1:0] own_addr;

  i2c_bus_cond u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .busy(busy)
  );

  i2c_rx_shifter u_shift (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .ack_val(ack_val), .sda_oe(sda_oe),
    .byte_done(byte_done), .byte_val(byte_val)
  );

  i2c_rx_regs #(.OWN_ADDR_RST(OWN_ADDR_RST)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .byte_done(byte_done), .byte_val(byte_val),
    .stop_det(stop_det), .busy(busy), .own_addr(own_addr), .ack_val(ack_val)
  );
endmodule

// File: tb/test_i2c_slave_rx.sv
module test_i2c_slave_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_wr = 1'b0, reg_rd = 1'b0, irq;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata, rd_val;
  logic ack_seen;
  wire  sda_bus = sda_m & ~sda_oe;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_slave_rx #(.OWN_ADDR_RST(OWN)) i_i2c_slave_rx (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; rd_val = reg_rdata;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; idle(HALF);
    scl_m = 1'b1; idle(HALF);
    sda_m = 1'b0; idle(HALF);
    scl_m = 1'b0; idle(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; idle(HALF);
    scl_m = 1'b1; idle(HALF);
    sda_m = 1'b1; idle(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; idle(HALF);
      scl_m = 1'b1; idle(HALF);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; idle(HALF);
    ack_seen = sda_bus;
    scl_m = 1'b1; idle(HALF);
    scl_m = 1'b0; idle(HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(5); rst = 1'b0; idle(2);
    // R1 reset state
    chk("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    reg_read(2'd0); chk("R1 ctrl", rd_val, 8'h00);
    reg_read(2'd1); chk("R1 own", rd_val, {1'b0, OWN});
    reg_read(2'd2); chk("R1 status", rd_val, 8'h00);

    reg_write(2'd0, 8'h04);                       // stop interrupt masked
    // R2 busy and stop flag
    bus_start();
    reg_read(2'd2); chk("R2 busy after start", rd_val, 8'h08);
    bus_stop();
    reg_read(2'd2); chk("R2/R8 stop masked", rd_val, 8'h04);
    reg_write(2'd2, 8'h00);
    reg_read(2'd2); chk("R10 clear stop", rd_val, 8'h00);

    // R3 address sweep: only the own address is acknowledged
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({a[6:0], 1'b0});
      if (a[6:0] == OWN) begin
        chk("R3 ack on match", {7'd0, ack_seen}, 8'h00);
        reg_read(2'd2); chk("R5 status after addr", rd_val, 8'h0B);
        reg_read(2'd3); chk("R5 addr byte", rd_val, {OWN, 1'b0});
        reg_write(2'd2, 8'h00);
      end else begin
        chk("R3 no ack on mismatch", {7'd0, ack_seen}, 8'h01);
        send_byte(8'h00);
        chk("R3 ignored data", {7'd0, ack_seen}, 8'h01);
        reg_read(2'd2); chk("R3 no flags", rd_val, 8'h08);
      end
      bus_stop();
      reg_write(2'd2, 8'h00);
    end

    // R3 direction bit 1 is not selected
    bus_start(); send_byte({OWN, 1'b1});
    chk("R3 read dir ignored", {7'd0, ack_seen}, 8'h01);
    bus_stop(); reg_write(2'd2, 8'h00);

    // R3 reprogrammed own address
    reg_write(2'd1, 8'h15);
    bus_start(); send_byte(8'h2A);
    chk("R3 new own addr", {7'd0, ack_seen}, 8'h00);
    reg_read(2'd3); chk("R5 new addr byte", rd_val, 8'h2A);
    bus_stop(); reg_write(2'd2, 8'h00);
    reg_write(2'd1, {1'b0, OWN});

    // R5 data sweep over all byte values
    bus_start(); send_byte({OWN, 1'b0});
    reg_read(2'd3); reg_write(2'd2, 8'h00);
    for (int v = 0; v < 256; v++) begin
      send_byte(v[7:0]);
      chk("R4 ack low", {7'd0, ack_seen}, 8'h00);
      chk("R4 released", {7'd0, sda_oe}, 8'h00);
      reg_read(2'd2); chk("R5 pend full", rd_val, 8'h0B);
      reg_read(2'd3); chk("R5 data", rd_val, v[7:0]);
      reg_write(2'd2, 8'h00);
    end
    // R3 repeated start with a foreign address
    bus_start(); send_byte(8'h20);
    chk("R3 rstart mismatch", {7'd0, ack_seen}, 8'h01);
    send_byte(8'h55);
    chk("R3 rstart ignored", {7'd0, ack_seen}, 8'h01);
    bus_stop(); reg_write(2'd2, 8'h00);

    // R4 negative acknowledge still delivers the byte
    reg_write(2'd0, 8'h05);
    bus_start(); send_byte({OWN, 1'b0});
    chk("R4 nack released", {7'd0, ack_seen}, 8'h01);
    reg_read(2'd3); chk("R4 nack byte kept", rd_val, {OWN, 1'b0});
    bus_stop(); reg_write(2'd2, 8'h00);
    reg_write(2'd0, 8'h04);

    // R6 double buffering
    bus_start(); send_byte({OWN, 1'b0});
    send_byte(8'hA1);
    reg_write(2'd2, 8'h00);
    reg_read(2'd3); chk("R6 first byte", rd_val, {OWN, 1'b0});
    reg_read(2'd2); chk("R6 refill sets pend full", rd_val, 8'h0B);
    reg_write(2'd2, 8'h00);
    reg_read(2'd3); chk("R6 second byte", rd_val, 8'hA1);
    reg_read(2'd2); chk("R6 empty", rd_val, 8'h08);
    // R7 overrun
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    reg_read(2'd2); chk("R7 overrun set", rd_val, 8'h1B);
    reg_read(2'd3); chk("R7 oldest kept", rd_val, 8'h11);
    reg_read(2'd3); chk("R7 second kept", rd_val, 8'h22);
    reg_read(2'd2); chk("R7 status", rd_val, 8'h19);
    // R10 write-one leaves flags alone
    reg_write(2'd2, 8'hEF);
    reg_read(2'd2); chk("R10 only overrun cleared", rd_val, 8'h09);
    reg_write(2'd2, 8'h00);
    reg_read(2'd2); chk("R10 pend cleared", rd_val, 8'h08);

    // R8 stop interrupt unmasked
    reg_write(2'd0, 8'h00);
    bus_stop();
    reg_read(2'd2); chk("R8 stop sets pend", rd_val, 8'h05);
    chk("R9 irq off when disabled", {7'd0, irq}, 8'h00);
    reg_write(2'd0, 8'h02);
    chk("R9 irq on", {7'd0, irq}, 8'h01);
    reg_write(2'd2, 8'h00);
    chk("R9 irq off after clear", {7'd0, irq}, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule